// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM channel and takes the memory from power-on to a usable state. After reset it keeps clock enable low while the clock runs for the stable-clock interval. It then raises clock enable and drives a fixed series of commands with fixed gaps between them. The series is: precharge of all banks, an extended mode register write that turns the DLL on, a mode register write that resets the DLL, a wait for the DLL to lock, a second precharge of all banks, a run of auto refreshes, and a last mode register write with the DLL reset bit cleared.

Every gap is a module parameter counted in clock cycles. All command and address outputs come straight from flops. When no command is being sent, the block drives NOP. A done flag rises once the last mode register write has settled. After that, a one-cycle request repeats the DLL reset and its lock wait, so the DLL can relock after the clock frequency changes. The normal read, write and refresh traffic that follows is handled by other logic.

Command encodings on {cs_n, ras_n, cas_n, we_n} are: NOP 0111, PRECHARGE 0010, AUTO REFRESH 0001, MODE REGISTER WRITE 0000. Cycle numbers below count rising edges after reset is released, where edge 0 is the first one.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is held, and up to edge WAIT_CYC-2, `cke` is 0. It becomes 1 at edge WAIT_CYC-1 and stays 1 from then on.
- R2: In every cycle that carries no command, the outputs are {cs_n, ras_n, cas_n, we_n} = 0111, with `ba` = 0 and `addr` = 0. This includes every cycle during reset and while `cke` is low.
- R3: T_NOP cycles after `cke` rises, the block sends PRECHARGE (0010) with `addr[10]` = 1, all other address bits 0, and `ba` = 0.
- R4: T_RP cycles after that precharge, the block sends MODE REGISTER WRITE with `ba` = 01 and `addr` = 0. The value 0 in `addr[0]` enables the DLL.
- R5: T_MRD cycles later, the block sends MODE REGISTER WRITE with `ba` = 00, `addr[6:0]` = MODE_VAL, `addr[8]` = 1 (DLL reset) and all other bits 0.
- R6: T_DLL cycles after the DLL reset write, the block sends a second PRECHARGE like the one in R3. T_RP cycles after that, it sends the first AUTO REFRESH (0001) with `ba` and `addr` at 0.
- R7: The block sends N_REF auto refreshes, each T_RFC cycles after the one before. T_RFC cycles after the last one, it sends MODE REGISTER WRITE with `ba` = 00, `addr[6:0]` = MODE_VAL and `addr[8]` = 0.
- R8: `init_done` rises exactly T_MRD cycles after the final mode register write. It then stays high, with no command sent, until a re-initialize request arrives.
- R9: If `dll_reinit` is high at an edge while `init_done` is 1, `init_done` falls at that edge. At the next edge the block sends the DLL reset write of R5. T_DLL cycles later it sends the final write of R7, and T_MRD cycles after that `init_done` rises again.
- R10: A `dll_reinit` pulse while `init_done` is 0 has no effect: no extra command is sent and the schedule does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dll_reinit | input | 1 | Request to repeat the DLL reset, for example after a frequency change |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address bus, which also carries the mode register fields |
| init_done | output | 1 | High once the memory is initialized |

## Verification
Each command leaves the design one edge after its wait counter reaches zero. The bench therefore derives every command's cycle by adding the parameter gaps to the cycle at which `cke` rises (edge WAIT_CYC-1). It places those cycle stamps, together with the expected bus values, into the scoreboard queue. A request sampled at edge m drops `init_done` at edge m and puts the DLL reset write out at edge m+1. The expected level of the done flag for each cycle is derived from those same sums. The monitor samples on the falling edge, halfway between the edge that updates the outputs and the next one. Any command that is not at the head of the queue, or that appears in the wrong cycle, fails.

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int WAIT_CYC = 10000,
  parameter int T_NOP    = 1,
  parameter int T_RP     = 3,
  parameter int T_MRD    = 2,
  parameter int T_RFC    = 6,
  parameter int T_DLL    = 200,
  parameter int N_REF    = 2,
  parameter int ADDR_W   = 12,
  parameter logic [6:0] MODE_VAL = 7'h32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dll_reinit,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);
  localparam int CW = $clog2(WAIT_CYC + T_DLL + T_RFC + 2);
  localparam int NW = $clog2(N_REF + 1);
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;
  localparam logic [ADDR_W-1:0] A_PRE  = ADDR_W'(1) << 10;
  localparam logic [ADDR_W-1:0] A_MFIN = ADDR_W'(MODE_VAL);
  localparam logic [ADDR_W-1:0] A_MRST = A_MFIN | (ADDR_W'(1) << 8);

  typedef enum logic [3:0] {
    S_PWR, S_PRE1, S_EMRS, S_MRST, S_PRE2, S_REF, S_MFIN, S_DONE
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [NW-1:0] nref;
  logic [3:0]    cmd;
  logic          reinit;

  assign {cs_n, ras_n, cas_n, we_n} = cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_PWR;
      cnt       <= CW'(WAIT_CYC - 1);
      nref      <= '0;
      cke       <= 1'b0;
      cmd       <= C_NOP;
      ba        <= '0;
      addr      <= '0;
      init_done <= 1'b0;
      reinit    <= 1'b0;
    end else begin
      cmd  <= C_NOP;
      ba   <= '0;
      addr <= '0;
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (st)
          S_PWR: begin
            cke <= 1'b1;
            cnt <= CW'(T_NOP - 1);
            st  <= S_PRE1;
          end
          S_PRE1, S_PRE2: begin
            cmd  <= C_PRE;
            addr <= A_PRE;
            cnt  <= CW'(T_RP - 1);
            st   <= (st == S_PRE1) ? S_EMRS : S_REF;
          end
          S_EMRS: begin
            cmd <= C_LMR;
            ba  <= 2'b01;
            cnt <= CW'(T_MRD - 1);
            st  <= S_MRST;
          end
          S_MRST: begin
            cmd  <= C_LMR;
            addr <= A_MRST;
            cnt  <= CW'(T_DLL - 1);
            st   <= reinit ? S_MFIN : S_PRE2;
          end
          S_REF: begin
            cmd <= C_REF;
            cnt <= CW'(T_RFC - 1);
            if (nref == NW'(N_REF - 1)) begin
              nref <= '0;
              st   <= S_MFIN;
            end else begin
              nref <= nref + 1'b1;
            end
          end
          S_MFIN: begin
            cmd  <= C_LMR;
            addr <= A_MFIN;
            cnt  <= CW'(T_MRD - 1);
            st   <= S_DONE;
          end
          S_DONE: begin
            if (!init_done) begin
              init_done <= 1'b1;
              reinit    <= 1'b0;
            end else if (dll_reinit) begin
              init_done <= 1'b0;
              reinit    <= 1'b1;
              st        <= S_MRST;
            end
          end
          default: st <= S_PWR;
        endcase
      end
    end
  end
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dll_reinit,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [1:0]        ba,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done
);
  logic is_nop, is_pre, is_lmr;
  assign is_nop = !cs_n && ras_n && cas_n && we_n;
  assign is_pre = !cs_n && !ras_n && cas_n && !we_n;
  assign is_lmr = !cs_n && !ras_n && !cas_n && !we_n;

  AST_CKE_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) cke |=> cke); // R1
  AST_NOP_WHILE_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !cke |-> is_nop); // R2
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n) is_pre |-> addr[10]); // R3
  AST_MODE_WRITE_FIELDS: assert property (@(posedge clk) disable iff (!rst_n) is_lmr |-> (!ba[1] && !addr[7])); // R5
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) init_done |-> is_nop); // R8
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (init_done && !dll_reinit) |=> init_done); // R8
  AST_DONE_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $fell(init_done) |-> $past(dll_reinit)); // R9
  AST_REINIT_DLL_RESET: assert property (@(posedge clk) disable iff (!rst_n) $fell(init_done) |=> (is_lmr && addr[8] && ba == 2'b00)); // R9
endmodule

bind ddr_init_seq ddr_init_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_ddr_init_seq.sv
`timescale 1ns/1ps
module sim_ddr_init_seq;
  localparam int W = 10000, TNOP = 1, TRP = 3, TMRD = 2, TRFC = 6, TDLL = 200, NREF = 2;
  localparam logic [6:0] MODE = 7'h32;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, LMR = 4'b0000;
  localparam int C_CKE = W - 1;
  localparam int C_PRE1 = C_CKE + TNOP;
  localparam int C_EMRS = C_PRE1 + TRP;
  localparam int C_MRST = C_EMRS + TMRD;
  localparam int C_PRE2 = C_MRST + TDLL;
  localparam int C_REF1 = C_PRE2 + TRP;
  localparam int C_MFIN = C_REF1 + NREF * TRFC;
  localparam int C_DONE = C_MFIN + TMRD;
  localparam int C_REQ  = C_DONE + 80;
  localparam int C_MRST2 = C_REQ + 2;
  localparam int C_MFIN2 = C_MRST2 + TDLL;
  localparam int C_DONE2 = C_MFIN2 + TMRD;
  localparam int C_END = C_DONE2 + 60;

  logic clk = 0, rst_n = 0, dll_reinit = 0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0] ba;
  logic [11:0] addr;
  int tests = 0, fails = 0, cyc = -1;
  bit finished = 0;

  typedef struct {
    int cyc; logic [3:0] cmd; logic [1:0] ba; logic [11:0] addr; string req;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  ddr_init_seq u0 (.clk(clk), .rst_n(rst_n), .dll_reinit(dll_reinit), .cke(cke),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .init_done(init_done));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic push(input int c, input logic [3:0] k, input logic [1:0] b,
                      input logic [11:0] a, input string req);
    item_t it;
    it.cyc = c; it.cmd = k; it.ba = b; it.addr = a; it.req = req;
    q.push_back(it);
  endtask

  task automatic wait_cyc(input int c);
    forever begin
      @(negedge clk); #2;
      if (cyc >= c) break;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      item_t it;
      logic exp_done;
      cyc++;
      exp_done = (cyc >= C_DONE && cyc <= C_REQ) || cyc >= C_DONE2;
      if (cke !== (cyc >= C_CKE)) check("R1", 32'(cke), 32'(cyc >= C_CKE));
      else tests++;
      if (init_done !== exp_done) check("R8 R9", 32'(init_done), 32'(exp_done));
      else tests++;
      if ({cs_n, ras_n, cas_n, we_n} != NOP) begin
        if (q.size() == 0) begin
          check("R2 R10 unexpected command", 32'({cs_n, ras_n, cas_n, we_n}), 32'(NOP));
        end else begin
          it = q.pop_front();
          check({it.req, " cycle"}, 32'(cyc), 32'(it.cyc));
          check({it.req, " cmd"}, 32'({cs_n, ras_n, cas_n, we_n}), 32'(it.cmd));
          check({it.req, " ba"}, 32'(ba), 32'(it.ba));
          check({it.req, " addr"}, 32'(addr), 32'(it.addr));
        end
      end else begin
        if (ba !== 2'b00 || addr !== 12'h000) check("R2 idle bus", 32'({ba, addr}), 32'h0);
      end
    end
  end

  initial begin
    push(C_PRE1, PRE, 2'b00, 12'h400, "R3");
    push(C_EMRS, LMR, 2'b01, 12'h000, "R4");
    push(C_MRST, LMR, 2'b00, 12'h100 | 12'(MODE), "R5");
    push(C_PRE2, PRE, 2'b00, 12'h400, "R6");
    for (int i = 0; i < NREF; i++) push(C_REF1 + i * TRFC, REF, 2'b00, 12'h000, "R6 R7");
    push(C_MFIN, LMR, 2'b00, 12'(MODE), "R7");
    push(C_MRST2, LMR, 2'b00, 12'h100 | 12'(MODE), "R9");
    push(C_MFIN2, LMR, 2'b00, 12'(MODE), "R9");

    repeat (3) @(negedge clk);
    #2;
    check("R1 reset cke", 32'(cke), 32'h0);
    check("R2 reset cmd", 32'({cs_n, ras_n, cas_n, we_n}), 32'(NOP));
    check("R8 reset done", 32'(init_done), 32'h0);
    rst_n = 1;

    wait_cyc(C_REF1 + 1);
    dll_reinit = 1;
    @(negedge clk); #2;
    dll_reinit = 0;
    repeat (3) @(negedge clk);
    #2;
    check("R10 done stays low", 32'(init_done), 32'h0);

    wait_cyc(C_REQ);
    dll_reinit = 1;
    @(negedge clk); #2;
    dll_reinit = 0;

    wait_cyc(C_MRST2 + 50);
    dll_reinit = 1;
    @(negedge clk); #2;
    dll_reinit = 0;

    wait_cyc(C_END);
    check("R9 R10 all commands seen", 32'(q.size()), 32'h0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired at cycle %0d: actual hung expected finish", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule